// File: doc/BRIEF.md
# Multiplexed-Bus One-Time-Programmable Byte Memory

This block is a clocked, synthesizable functional model of a byte-wide one-time-programmable memory that connects to a processor's shared address/data bus. A single active-low select pin, `ale_sel_n`, does two jobs. On its high-to-low transition the block stores the address bus in an internal register. While it stays low the chip is selected and the address pins are free to carry data. An output-enable pin and a program strobe, together with two level flags, choose what the block does. One flag marks that the programming supply is present. The other marks that the high-voltage identifier condition is applied to address bit 9.

All pins are sampled on the rising clock edge, and the data output is registered. Tri-state is represented by a separate `dout_en` flag, and `dout` is held at zero whenever that flag is low. Programming can only clear bits. An erase command sweeps the array back to all-ones, one location per clock. A saturating debug counter records program strobes that arrive outside a valid program condition. Parameters choose the array depth, whether the address register is used or the address passes straight through, and the package variant that sets the manufacturer code.

Top module: `otp_mux_mem`

## Requirements
- R1: With LATCHED=1, the address present in the cycle where `ale_sel_n` is first seen low after being high is stored. Later address changes have no effect on reads or writes until the next such transition.
- R2: With LATCHED=0, the address pins are used directly, so a change of `addr` while selected is reflected in `dout` on the next clock edge.
- R3: Read mode (`ale_sel_n`=0, `oe_n`=0, `prog_n`=1, identifier not active) sets `dout_en`=1 and `dout` to the stored byte at the next clock edge.
- R4: When `ale_sel_n`=1 (for any `oe_n`), or when `ale_sel_n`=0 with `oe_n`=1, the next clock edge gives `dout_en`=0 and `dout`=0x00.
- R5: A pulse on `erase_req` writes 0xFF to every location, one per clock, and then sets `erase_done`. `erase_done` is cleared by reset and when a new erase starts.
- R6: A falling edge of `prog_n`, seen while `vpp_hi`=1, `ale_sel_n`=0 and `oe_n`=1, writes `din` into the selected location.
- R7: A program write stores the old byte ANDed with `din`, so no bit ever goes from 0 to 1 through programming.
- R8: Verify mode (`vpp_hi`=1, `ale_sel_n`=0, `oe_n`=0, `prog_n`=1) returns the stored byte exactly as a read does.
- R9: A falling edge of `prog_n` under any other condition leaves the array unchanged. This includes `ale_sel_n`=1 (program inhibit), `oe_n`=0, `vpp_hi`=0, and an erase in progress. Each such edge increments `bad_wr_cnt`, which saturates at its maximum value.
- R10: In read conditions with `id_hv`=1 and every address bit other than bits 0 and 9 low, `dout` is an identifier byte. Bit 0 low gives the manufacturer code: 0x89 with WINDOWED=1, 0x88 with WINDOWED=0. Bit 0 high gives the device code: 0x37 with LATCHED=1, 0x07 with LATCHED=0. If the other address bits are not all low, the array is read.
- R11: With LATCHED=1, identifier bytes are returned only after at least one select transition since reset. Before that, the array at the reset address 0 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset (does not clear the array) |
| ale_sel_n | input | 1 | Combined address-strobe and chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_n | input | 1 | Program strobe, write on its falling edge |
| vpp_hi | input | 1 | Programming supply present |
| id_hv | input | 1 | High-voltage identifier condition on address bit 9 |
| addr | input | $clog2(DEPTH) | Address bus |
| din | input | 8 | Data to program |
| erase_req | input | 1 | Start a clear-to-ones sweep |
| dout | output | 8 | Registered read data, 0x00 when not driven |
| dout_en | output | 1 | High when the data pins would be driven |
| erase_done | output | 1 | Set when an erase sweep has finished |
| bad_wr_cnt | output | CNT_W | Saturating count of rejected program strobes |

## Verification
The assertions assume that reset is held low for at least two clock edges at start-up, so that every `$past` reference sees reset values. They also assume that no location is programmed before the first erase has run, because the stored bytes are undefined until then. The stimulus releases reset only after four cycles and erases both instances before any program strobe. It changes pins only on the falling clock edge, one bus phase per cycle, so every select and strobe transition lasts at least one full clock period.

// File: rtl/otp_pkg.sv
// otp_pkg: shared types and constants for the one-time-programmable memory model.
// Assumes a byte-wide array; identifier codes are fixed byte values.
package otp_pkg;

    localparam int BYTE_W = 8;
    localparam int ID_BIT = 9;

    localparam logic [BYTE_W-1:0] MFG_WINDOWED = 8'h89;
    localparam logic [BYTE_W-1:0] MFG_PLASTIC  = 8'h88;
    localparam logic [BYTE_W-1:0] DEV_LATCHED  = 8'h37;
    localparam logic [BYTE_W-1:0] DEV_DIRECT   = 8'h07;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_INHIBIT,
        MD_DISABLE,
        MD_READ,
        MD_VERIFY,
        MD_PROGRAM,
        MD_IDENT
    } otp_mode_e;

    // Identifier byte for a given address bit 0 and variant selection.
    function automatic logic [BYTE_W-1:0] id_byte(input logic dev_sel,
                                                  input bit latched,
                                                  input bit windowed);
        if (dev_sel)
            return latched ? DEV_LATCHED : DEV_DIRECT;
        else
            return windowed ? MFG_WINDOWED : MFG_PLASTIC;
    endfunction

    // True for modes in which the data pins are driven.
    function automatic logic drives_bus(input otp_mode_e m);
        return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDENT);
    endfunction

endpackage

// File: rtl/otp_addr_stage.sv
// otp_addr_stage: produces the effective array address.
// LATCHED=1: stores addr when sel_n is seen low after being high; the stored
// value resets to 0 and latch_seen marks that a capture has happened.
// LATCHED=0: addr passes straight through and latch_seen is tied high.
// Assumes sel_n and addr are synchronous to clk.
module otp_addr_stage #(
    parameter int AW      = 11,
    parameter bit LATCHED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] eff_addr,
    output logic          latch_seen
);

    generate
        if (LATCHED) begin : g_latch
            logic          sel_q;
            logic [AW-1:0] lat_addr;
            logic          seen_q;
            logic          fall;

            assign fall = sel_q && !sel_n;

            // Track the previous select level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) sel_q <= 1'b0;
                else        sel_q <= sel_n;
            end

            // Capture the address on a select high-to-low transition.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lat_addr <= '0;
                    seen_q   <= 1'b0;
                end else if (fall) begin
                    lat_addr <= addr;
                    seen_q   <= 1'b1;
                end
            end

            assign eff_addr   = lat_addr;
            assign latch_seen = seen_q;

            // R1
            latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(sel_q && !sel_n) |=> $stable(lat_addr));
        end else begin : g_direct
            assign eff_addr   = addr;
            assign latch_seen = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/otp_mode_dec.sv
// otp_mode_dec: combinational decode of the control pins into one mode.
// Assumes eff_addr is the address the array is using this cycle and
// id_armed says whether identifier output is allowed at all.
module otp_mode_dec
    import otp_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          sel_n,
    input  logic          oe_n,
    input  logic          prog_n,
    input  logic          vpp_hi,
    input  logic          id_hv,
    input  logic          id_armed,
    input  logic [AW-1:0] eff_addr,
    output otp_mode_e     mode
);

    localparam logic [AW-1:0] ID_FREE = AW'((1 << ID_BIT) | 1);

    logic id_ok;
    assign id_ok = id_hv && id_armed && ((eff_addr & ~ID_FREE) == '0);

    // Priority decode: select, then program, then output gating.
    always_comb begin
        if (sel_n)
            mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
        else if (vpp_hi && oe_n && !prog_n)
            mode = MD_PROGRAM;
        else if (oe_n || !prog_n)
            mode = MD_DISABLE;
        else if (id_ok)
            mode = MD_IDENT;
        else if (vpp_hi)
            mode = MD_VERIFY;
        else
            mode = MD_READ;
    end

endmodule

// File: rtl/otp_array.sv
// otp_array: byte storage with an AND-only program port and an erase sweep.
// DEPTH must be a power of two. Contents are not reset; an erase sweep
// must run before the stored data is defined.
module otp_array
    import otp_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_req,
    input  logic              prog_we,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              erasing,
    output logic              erase_done
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     sweep;

    // Erase sequencer: walks every location once, then flags completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erasing    <= 1'b0;
            erase_done <= 1'b0;
            sweep      <= '0;
        end else if (erasing) begin
            if (sweep == AW'(DEPTH - 1)) begin
                erasing    <= 1'b0;
                erase_done <= 1'b1;
            end else begin
                sweep <= sweep + 1'b1;
            end
        end else if (erase_req) begin
            erasing    <= 1'b1;
            erase_done <= 1'b0;
            sweep      <= '0;
        end
    end

    // Single write port: erase fill has priority over programming.
    always_ff @(posedge clk) begin
        if (erasing)
            mem[sweep] <= '1;
        else if (prog_we)
            mem[wr_addr] <= mem[wr_addr] & wr_data;
    end

    assign rd_data = mem[rd_addr];

    logic [AW-1:0]     chk_addr;
    logic [BYTE_W-1:0] chk_old;

    // Snapshot of the write target, used only by the AND-only check.
    always_ff @(posedge clk) begin
        chk_addr <= wr_addr;
        chk_old  <= mem[wr_addr];
    end

    // R7
    and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && !erasing) |=> ((mem[chk_addr] & ~chk_old) == '0));

    // R5
    done_after_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_done) |-> $past(erasing));

endmodule

// File: rtl/otp_mux_mem.sv
// otp_mux_mem: top level of the multiplexed-bus one-time-programmable memory.
// Detects program strobes, gates writes by mode, counts rejected strobes and
// registers the data output. All pins are assumed synchronous to clk.
module otp_mux_mem
    import otp_pkg::*;
#(
    parameter int DEPTH    = 2048,
    parameter bit LATCHED  = 1'b1,
    parameter bit WINDOWED = 1'b1,
    parameter int CNT_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ale_sel_n,
    input  logic                     oe_n,
    input  logic                     prog_n,
    input  logic                     vpp_hi,
    input  logic                     id_hv,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [7:0]               din,
    input  logic                     erase_req,
    output logic [7:0]               dout,
    output logic                     dout_en,
    output logic                     erase_done,
    output logic [CNT_W-1:0]         bad_wr_cnt
);

    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0]     eff_addr;
    logic              latch_seen;
    otp_mode_e         mode;
    logic [BYTE_W-1:0] rd_data;
    logic              erasing;
    logic              prog_q;
    logic              prog_fall;
    logic              prog_we;

    otp_addr_stage #(.AW(AW), .LATCHED(LATCHED)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_n      (ale_sel_n),
        .addr       (addr),
        .eff_addr   (eff_addr),
        .latch_seen (latch_seen)
    );

    otp_mode_dec #(.AW(AW)) u_dec (
        .sel_n    (ale_sel_n),
        .oe_n     (oe_n),
        .prog_n   (prog_n),
        .vpp_hi   (vpp_hi),
        .id_hv    (id_hv),
        .id_armed (latch_seen),
        .eff_addr (eff_addr),
        .mode     (mode)
    );

    otp_array #(.DEPTH(DEPTH)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .erase_req  (erase_req),
        .prog_we    (prog_we),
        .wr_addr    (eff_addr),
        .wr_data    (din),
        .rd_addr    (eff_addr),
        .rd_data    (rd_data),
        .erasing    (erasing),
        .erase_done (erase_done)
    );

    // Previous strobe level for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_q <= 1'b1;
        else        prog_q <= prog_n;
    end

    assign prog_fall = prog_q && !prog_n;
    assign prog_we   = prog_fall && (mode == MD_PROGRAM) && !erasing;

    // Saturating count of strobes that did not produce a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bad_wr_cnt <= '0;
        else if (prog_fall && !prog_we && (bad_wr_cnt != '1))
            bad_wr_cnt <= bad_wr_cnt + 1'b1;
    end

    // Registered output: identifier byte, array byte, or zero when floating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= drives_bus(mode);
            if (mode == MD_IDENT)
                dout <= id_byte(eff_addr[0], LATCHED, WINDOWED);
            else if (drives_bus(mode))
                dout <= rd_data;
            else
                dout <= '0;
        end
    end

    // R4
    standby_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_sel_n |=> !dout_en);

    // R3
    drive_needs_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(!ale_sel_n && !oe_n && prog_n));

    // R9
    bad_cnt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_wr_cnt != $past(bad_wr_cnt)) |-> $past(prog_q && !prog_n));

endmodule

// File: tb/otp_mux_mem_bench.sv
// Bench: exhaustive sweep of a 1024-byte latched instance plus a direct one.
module otp_mux_mem_bench;

    localparam int D  = 1024;
    localparam int AW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic l_sel = 1'b1, l_oe = 1'b1, l_prog = 1'b1, l_vpp = 1'b0, l_id = 1'b0, l_er = 1'b0;
    logic [AW-1:0] l_addr = '0;
    logic [7:0]    l_din = '0, l_dout;
    logic          l_en, l_done;
    logic [7:0]    l_bad;

    logic f_sel = 1'b1, f_oe = 1'b1, f_prog = 1'b1, f_vpp = 1'b0, f_id = 1'b0, f_er = 1'b0;
    logic [AW-1:0] f_addr = '0;
    logic [7:0]    f_din = '0, f_dout;
    logic          f_en, f_done;
    logic [7:0]    f_bad;

    otp_mux_mem #(.DEPTH(D), .LATCHED(1'b1), .WINDOWED(1'b1)) u_otp_mux_mem (
        .clk(clk), .rst_n(rst_n), .ale_sel_n(l_sel), .oe_n(l_oe), .prog_n(l_prog),
        .vpp_hi(l_vpp), .id_hv(l_id), .addr(l_addr), .din(l_din), .erase_req(l_er),
        .dout(l_dout), .dout_en(l_en), .erase_done(l_done), .bad_wr_cnt(l_bad));

    otp_mux_mem #(.DEPTH(D), .LATCHED(1'b0), .WINDOWED(1'b0)) u_flat (
        .clk(clk), .rst_n(rst_n), .ale_sel_n(f_sel), .oe_n(f_oe), .prog_n(f_prog),
        .vpp_hi(f_vpp), .id_hv(f_id), .addr(f_addr), .din(f_din), .erase_req(f_er),
        .dout(f_dout), .dout_en(f_en), .erase_done(f_done), .bad_wr_cnt(f_bad));

    int nchk = 0, nerr = 0;
    bit finished = 1'b0;

    function automatic logic [7:0] pat1(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction
    function automatic logic [7:0] pat2(input int a);
        return 8'(a & 255) ^ 8'hA5 ^ {a[9:8], 6'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic l_read(input logic [AW-1:0] a, input logic vpp,
                          output logic [7:0] d, output logic en);
        l_sel = 1'b1; l_addr = a; @(negedge clk);
        l_sel = 1'b0; @(negedge clk);
        l_addr = ~a; l_vpp = vpp; l_oe = 1'b0; @(negedge clk);
        d = l_dout; en = l_en;
        l_oe = 1'b1; l_sel = 1'b1; l_vpp = 1'b0;
    endtask

    task automatic l_write(input logic [AW-1:0] a, input logic [7:0] d);
        l_sel = 1'b1; l_addr = a; @(negedge clk);
        l_sel = 1'b0; @(negedge clk);
        l_addr = ~a; l_din = d; l_vpp = 1'b1; @(negedge clk);
        l_prog = 1'b0; @(negedge clk);
        l_prog = 1'b1; l_vpp = 1'b0; l_sel = 1'b1;
    endtask

    task automatic f_write(input logic [AW-1:0] a, input logic [7:0] d);
        f_addr = a; f_din = d; f_vpp = 1'b1; f_sel = 1'b0; @(negedge clk);
        f_prog = 1'b0; @(negedge clk);
        f_prog = 1'b1; f_vpp = 1'b0; f_sel = 1'b1;
    endtask

    task automatic f_read(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
        f_addr = a; f_sel = 1'b0; f_oe = 1'b0; @(negedge clk);
        d = f_dout; en = f_en;
        f_oe = 1'b1; f_sel = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic en;
        int waited;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset dout_en", 32'(l_en), 0);
        chk("R5 reset erase_done", 32'(l_done), 0);
        chk("R9 reset bad count", 32'(l_bad), 0);

        // R5 erase both instances
        l_er = 1'b1; f_er = 1'b1; @(negedge clk);
        l_er = 1'b0; f_er = 1'b0;
        chk("R5 done cleared at start", 32'(l_done), 0);
        waited = 0;
        while (!(l_done && f_done) && waited < D + 20) begin
            @(negedge clk); waited++;
        end
        chk("R5 erase finished", 32'(l_done && f_done), 1);

        for (int a = 0; a < D; a++) begin
            l_read(AW'(a), 1'b0, d, en);
            chk("R5 erased byte", {23'(0), en, d}, {23'(0), 1'b1, 8'hFF});
        end
        for (int a = 0; a < D; a++) l_write(AW'(a), pat1(a));
        for (int a = 0; a < D; a++) begin
            l_read(AW'(a), 1'b0, d, en);
            chk("R1 R3 R6 latched read", {23'(0), en, d}, {23'(0), 1'b1, pat1(a)});
        end
        for (int a = 0; a < D; a++) l_write(AW'(a), pat2(a));
        for (int a = 0; a < D; a++) begin
            l_read(AW'(a), 1'b0, d, en);
            chk("R7 and-only program", 32'(d), 32'(pat1(a) & pat2(a)));
        end

        // R8 verify mode
        l_read(AW'(5), 1'b1, d, en);
        chk("R8 verify read", {23'(0), en, d}, {23'(0), 1'b1, pat1(5) & pat2(5)});

        // R4 output disable and standby
        l_sel = 1'b1; l_addr = AW'(6); @(negedge clk);
        l_sel = 1'b0; l_oe = 1'b1; @(negedge clk);
        chk("R4 output disable", {23'(0), l_en, l_dout}, 0);
        l_sel = 1'b1; l_oe = 1'b0; @(negedge clk);
        chk("R4 standby ignores oe", {23'(0), l_en, l_dout}, 0);
        l_oe = 1'b1;

        // R9 rejected strobes
        l_sel = 1'b1; l_addr = AW'(7); @(negedge clk);
        l_sel = 1'b0; @(negedge clk);
        l_vpp = 1'b1; l_oe = 1'b0; l_din = 8'h00; @(negedge clk);
        l_prog = 1'b0; @(negedge clk);
        l_prog = 1'b1;
        chk("R9 strobe with oe low counted", 32'(l_bad), 1);
        l_oe = 1'b1; l_sel = 1'b1; @(negedge clk);
        l_prog = 1'b0; @(negedge clk);
        l_prog = 1'b1;
        chk("R9 inhibit strobe counted", 32'(l_bad), 2);
        l_vpp = 1'b0; l_sel = 1'b0; @(negedge clk);
        l_prog = 1'b0; @(negedge clk);
        l_prog = 1'b1; l_sel = 1'b1; @(negedge clk);
        chk("R9 strobe without vpp counted", 32'(l_bad), 3);
        l_read(AW'(7), 1'b0, d, en);
        chk("R9 array untouched", 32'(d), 32'(pat1(7) & pat2(7)));

        // R10 identifier, latched windowed instance
        l_id = 1'b1;
        l_read(AW'(0), 1'b0, d, en);
        chk("R10 manufacturer 0x89", {23'(0), en, d}, {23'(0), 1'b1, 8'h89});
        l_read(AW'(1), 1'b0, d, en);
        chk("R10 device 0x37", 32'(d), 32'h37);
        l_read(AW'(10'h201), 1'b0, d, en);
        chk("R10 bit 9 free", 32'(d), 32'h37);
        l_read(AW'(3), 1'b0, d, en);
        chk("R10 other bit set reads array", 32'(d), 32'(pat1(3) & pat2(3)));
        l_id = 1'b0;

        // R2 direct instance
        for (int a = 0; a < D; a++) f_write(AW'(a), pat1(a));
        for (int a = 0; a < D; a++) begin
            f_read(AW'(a), d, en);
            chk("R2 direct read", {23'(0), en, d}, {23'(0), 1'b1, pat1(a)});
        end
        f_sel = 1'b0; f_oe = 1'b0; f_addr = AW'(10); @(negedge clk);
        chk("R2 follows addr a", 32'(f_dout), 32'(pat1(10)));
        f_addr = AW'(20); @(negedge clk);
        chk("R2 follows addr b", 32'(f_dout), 32'(pat1(20)));
        f_oe = 1'b1; f_sel = 1'b1;
        f_id = 1'b1;
        f_read(AW'(0), d, en);
        chk("R10 manufacturer 0x88", 32'(d), 32'h88);
        f_read(AW'(1), d, en);
        chk("R10 device 0x07", 32'(d), 32'h07);
        f_id = 1'b0;

        // R11 identifier needs a select transition after reset
        l_sel = 1'b0; l_oe = 1'b1; l_addr = '0; @(negedge clk);
        rst_n = 1'b0; repeat (3) @(negedge clk);
        rst_n = 1'b1; @(negedge clk);
        chk("R5 reset clears done", 32'(l_done), 0);
        l_id = 1'b1; l_oe = 1'b0; @(negedge clk);
        chk("R11 no latch yet reads array", {23'(0), l_en, l_dout},
            {23'(0), 1'b1, pat1(0) & pat2(0)});
        l_oe = 1'b1; l_sel = 1'b1; @(negedge clk);
        l_sel = 1'b0; @(negedge clk);
        l_oe = 1'b0; @(negedge clk);
        chk("R11 after latch gives code", 32'(l_dout), 32'h89);
        l_oe = 1'b1; l_sel = 1'b1; l_id = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule